// File: doc/BRIEF.md
# PRBS Bit Error Rate Tester

This unit runs a bit error rate test on one serial time-division stream. A pattern generator places a 2^15-1 pseudo-random sequence (x^15 + x^14 + 1) into the output slots that a slot-valid strobe marks. On the return path, a checker takes the same slots, loads its own shift register from the first fifteen received bits, and then predicts every following bit. Each predicted bit that differs from the received bit adds one to a saturating 16-bit error count. The host reads that count at any time on a plain output.

A small control register holds an enable bit and a clear bit. The host writes it through a one-cycle write strobe. Enable gates both directions. While enable is low, the serial output sits at zero and the count keeps its value. Clear holds the count at zero for as long as it is set. The receiver needs a training period after enable. Errors are only counted once a set number of frame pulses has been seen since enable rose. The host is expected to clear the count once training ends. For a local port and a backplane port, the chip places two independent copies of this unit.

Top module: `prbs_ber_tester`

## Requirements
- R1: When enabled, the generator starts from the all-ones state on each rising edge of enable. Each output bit is s[14] XOR s[13] of the current state, and that bit is then shifted into s[0]. The first 14 bits are therefore zero. The state is never all zero.
- R2: While enable is 0, tx_bit is 0 on every cycle, whatever slot_valid does.
- R3: The generator and checker advance only on cycles with slot_valid high. While slot_valid is low, tx_bit holds its value and rx_bit is ignored.
- R4: The checker loads its register from 15 received slot bits and then tracks the stream. If the 15 loaded bits are all zero, it discards them and loads another 15.
- R5: Once armed and tracking, each received slot bit that differs from the prediction adds exactly one to err_count. Matching bits add nothing.
- R6: The checker arms after ARM_FRAMES (default 2) frame pulses have been seen since enable rose. Mismatches before that are not counted.
- R7: err_count stops at 0xFFFF and stays there until it is cleared. It never wraps.
- R8: While the clear bit is 1, err_count reads 0. Counting resumes after clear returns to 0.
- R9: A synchronous active-high reset zeroes the control register and err_count.
- R10: A write with ctl_we high loads ctl_wdata, with bit 0 as enable and bit 1 as clear. The new value acts from the next cycle.
- R11: Dropping enable leaves err_count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write data: bit 0 enable, bit 1 clear |
| slot_valid | input | 1 | High on cycles that carry a test slot bit |
| frame_pulse | input | 1 | One-cycle frame start marker |
| tx_bit | output | 1 | Serial pattern bit for the current slot |
| rx_bit | input | 1 | Returning serial bit for the current slot |
| err_count | output | CNT_W (16) | Saturating bit error count |

## Verification
The bench loops tx_bit back to rx_bit and flips chosen slots. After 65,540 flips it expects exactly 0xFFFF. A counter that wraps instead would read a small number.

A second case feeds all zeros into the checker while it is loading. A checker that kept an all-zero seed would then predict zeros forever and count errors on a clean loop.

Flips are also placed on cycles where slot_valid is low, and before the second frame pulse. A design that sampled outside slots or counted during training would show a non-zero count.

The bench also checks that clear holds the count at zero while errors keep arriving. It checks that re-enabling restarts the exact sequence from the all-ones seed.

// File: rtl/prbs_ber_pkg.sv
package prbs_ber_pkg;

    // Pattern register geometry: x^15 + x^14 + 1
    localparam int LFSR_W = 15;
    localparam int TAP_HI = 14;
    localparam int TAP_LO = 13;

    typedef logic [LFSR_W-1:0] lfsr_t;

    localparam lfsr_t LFSR_SEED = '1;

    // Control register layout: bit 1 clear, bit 0 enable
    typedef struct packed {
        logic clear;
        logic enable;
    } ber_ctl_t;

    typedef enum logic {
        CHK_SEED  = 1'b0,
        CHK_TRACK = 1'b1
    } chk_state_e;

    function automatic logic lfsr_out(input lfsr_t s);
        return s[TAP_HI] ^ s[TAP_LO];
    endfunction

    function automatic lfsr_t lfsr_push(input lfsr_t s, input logic b);
        return {s[LFSR_W-2:0], b};
    endfunction

endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
    import prbs_ber_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic adv,
    output logic bit_o
);

    lfsr_t lfsr_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            lfsr_q <= LFSR_SEED;
        end else if (adv) begin
            lfsr_q <= lfsr_push(lfsr_q, lfsr_out(lfsr_q));
        end
    end

    always_comb begin
        bit_o = en ? lfsr_out(lfsr_q) : 1'b0;
    end

    // R1
    gen_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

    // R3
    gen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !adv) |=> $stable(lfsr_q));

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
    import prbs_ber_pkg::*;
#(
    parameter int ARM_FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic adv,
    input  logic rx_bit,
    input  logic frame_pulse,
    output logic err_hit
);

    localparam int FW = $clog2(LFSR_W);
    localparam int AW = $clog2(ARM_FRAMES + 1);

    chk_state_e    state_q;
    lfsr_t         lfsr_q;
    logic [FW-1:0] fill_q;
    logic [AW-1:0] arm_q;
    logic          armed;
    logic          pred;
    lfsr_t         seed_next;

    always_comb begin
        pred      = lfsr_out(lfsr_q);
        seed_next = lfsr_push(lfsr_q, rx_bit);
        armed     = (arm_q == AW'(ARM_FRAMES));
        err_hit   = en && adv && (state_q == CHK_TRACK) && armed && (pred != rx_bit);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= CHK_SEED;
            lfsr_q  <= '0;
            fill_q  <= '0;
        end else if (adv) begin
            case (state_q)
                CHK_SEED: begin
                    lfsr_q <= seed_next;
                    if (fill_q == FW'(LFSR_W - 1)) begin
                        fill_q  <= '0;
                        state_q <= (seed_next == '0) ? CHK_SEED : CHK_TRACK;
                    end else begin
                        fill_q <= fill_q + 1'b1;
                    end
                end
                default: begin
                    lfsr_q <= lfsr_push(lfsr_q, pred);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            arm_q <= '0;
        end else if (frame_pulse && !armed) begin
            arm_q <= arm_q + 1'b1;
        end
    end

    // R4
    chk_track_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CHK_TRACK) |-> (lfsr_q != '0));

    // R6
    chk_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(frame_pulse));

endmodule

// File: rtl/ber_sat_counter.sv
module ber_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_q;
    logic         at_top;

    always_comb begin
        at_top = (cnt_q == '1);
        cnt    = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && !at_top) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '1 && !clr) |=> (cnt_q == '1));

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

    // R5
    step_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt_q == $past(cnt_q) || cnt_q == W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/prbs_ber_tester.sv
module prbs_ber_tester
    import prbs_ber_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int ARM_FRAMES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [1:0]       ctl_wdata,
    input  logic             slot_valid,
    input  logic             frame_pulse,
    output logic             tx_bit,
    input  logic             rx_bit,
    output logic [CNT_W-1:0] err_count
);

    ber_ctl_t ctl_q;
    logic     hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= ber_ctl_t'(ctl_wdata);
        end
    end

    prbs_gen u_gen (
        .clk   (clk),
        .rst   (rst),
        .en    (ctl_q.enable),
        .adv   (slot_valid),
        .bit_o (tx_bit)
    );

    prbs_chk #(.ARM_FRAMES(ARM_FRAMES)) u_chk (
        .clk         (clk),
        .rst         (rst),
        .en          (ctl_q.enable),
        .adv         (slot_valid),
        .rx_bit      (rx_bit),
        .frame_pulse (frame_pulse),
        .err_hit     (hit)
    );

    ber_sat_counter #(.W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (ctl_q.clear),
        .inc (hit),
        .cnt (err_count)
    );

    // R11
    hold_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.enable && !ctl_q.clear) |=> $stable(err_count));

endmodule

// File: tb/prbs_ber_tester_tb.sv
module prbs_ber_tester_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_wdata = 2'b00;
    logic        slot_valid = 1'b0;
    logic        frame_pulse = 1'b0;
    logic        flip = 1'b0;
    logic        rx_zero = 1'b0;
    logic        tx_bit;
    logic        rx_bit;
    logic [15:0] err_count;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    assign rx_bit = rx_zero ? 1'b0 : (tx_bit ^ flip);

    always #(CLK_PERIOD/2) clk = ~clk;

    prbs_ber_tester u_dut (
        .clk         (clk),
        .rst         (rst),
        .ctl_we      (ctl_we),
        .ctl_wdata   (ctl_wdata),
        .slot_valid  (slot_valid),
        .frame_pulse (frame_pulse),
        .tx_bit      (tx_bit),
        .rx_bit      (rx_bit),
        .err_count   (err_count)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic sv, input logic fl, input logic fp);
        @(negedge clk);
        slot_valid  = sv;
        flip        = fl;
        frame_pulse = fp;
    endtask

    task automatic ctl_write(input logic [1:0] v);
        @(negedge clk);
        slot_valid  = 1'b0;
        flip        = 1'b0;
        frame_pulse = 1'b0;
        ctl_we      = 1'b1;
        ctl_wdata   = v;
        @(negedge clk);
        ctl_we      = 1'b0;
    endtask

    // restart, seed the checker, arm with two frame pulses, clear the count
    task automatic arm_and_clear();
        ctl_write(2'b00);
        ctl_write(2'b01);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, (i == 3) || (i == 8));
        ctl_write(2'b11);
        ctl_write(2'b01);
    endtask

    task automatic t_reset();
        check("R9 count after reset", 32'(err_count), 32'h0);
        check("R9 tx after reset", 32'(tx_bit), 32'h0);
    endtask

    task automatic t_disabled_zero();
        int ones = 0;
        for (int i = 0; i < 40; i++) begin
            step(i[0], 1'b0, 1'b0);
            if (tx_bit) ones++;
        end
        check("R2 tx ones while disabled", 32'(ones), 32'h0);
    endtask

    task automatic t_pattern(input string req);
        logic [14:0] m = '1;
        int bad = 0;
        ctl_write(2'b00);
        ctl_write(2'b01);  // R10: acts from the next cycle
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            slot_valid = 1'b1;
            if (tx_bit !== (m[14] ^ m[13])) bad++;
            m = {m[13:0], m[14] ^ m[13]};
        end
        check(req, 32'(bad), 32'h0);
    endtask

    task automatic t_count();
        arm_and_clear();
        check("R5 clean loop after clear", 32'(err_count), 32'h0);
        for (int i = 0; i < 300; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R5 clean loop no errors", 32'(err_count), 32'h0);
        for (int i = 0; i < 111; i++) step(1'b1, (i % 3) == 0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R5 37 flips counted", 32'(err_count), 32'd37);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R5 adjacent flips counted", 32'(err_count), 32'd43);
    endtask

    task automatic t_gating();
        logic held;
        int moved = 0;
        step(1'b0, 1'b0, 1'b0);
        held = tx_bit;
        for (int i = 0; i < 25; i++) begin
            step(1'b0, 1'b1, 1'b0);
            if (tx_bit !== held) moved++;
        end
        check("R3 tx held outside slots", 32'(moved), 32'h0);
        step(1'b0, 1'b0, 1'b0);
        check("R3 flips outside slots ignored", 32'(err_count), 32'd43);
        for (int i = 0; i < 100; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R3 still aligned after gap", 32'(err_count), 32'd43);
    endtask

    task automatic t_clear();
        ctl_write(2'b11);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R8 count held at zero under clear", 32'(err_count), 32'h0);
        ctl_write(2'b01);
        for (int i = 0; i < 10; i++) step(1'b1, i < 5, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R8 counting resumes after release", 32'(err_count), 32'd5);
    endtask

    task automatic t_disable_hold();
        ctl_write(2'b00);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R11 count kept after disable", 32'(err_count), 32'd5);
        check("R2 tx zero after disable", 32'(tx_bit), 32'h0);
    endtask

    task automatic t_training();
        ctl_write(2'b10);
        ctl_write(2'b00);
        ctl_write(2'b01);
        for (int i = 0; i < 15; i++) step(1'b1, 1'b0, i == 2);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R6 no count before second frame", 32'(err_count), 32'h0);
        step(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b1, i < 3, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R6 counting once armed", 32'(err_count), 32'd3);
    endtask

    task automatic t_zero_seed();
        ctl_write(2'b00);
        ctl_write(2'b01);
        rx_zero = 1'b1;
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, (i == 2) || (i == 5));
        step(1'b0, 1'b0, 1'b0);
        rx_zero = 1'b0;
        for (int i = 0; i < 15; i++) step(1'b1, 1'b0, 1'b0);
        ctl_write(2'b11);
        ctl_write(2'b01);
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R4 reseed after all-zero load", 32'(err_count), 32'h0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R4 tracking after reseed", 32'(err_count), 32'd1);
    endtask

    task automatic t_saturation();
        arm_and_clear();
        for (int i = 0; i < 65540; i++) step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R7 saturated at 0xFFFF", 32'(err_count), 32'hFFFF);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R7 no wrap past 0xFFFF", 32'(err_count), 32'hFFFF);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 count zero after mid-run reset", 32'(err_count), 32'h0);
        rst = 1'b0;
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0);
        check("R9 enable cleared by reset", 32'(tx_bit), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled_zero();
        t_pattern("R1 sequence from seed");
        t_count();
        t_gating();
        t_clear();
        t_disable_hold();
        t_pattern("R11 sequence restarts on re-enable");
        t_training();
        t_zero_seed();
        t_saturation();
        t_reset_mid();
        finish_run();
    end

endmodule